// File: doc/BRIEF.md
# SPI memory slave command decoder

This block is the serial front end of a byte-addressable nonvolatile memory. It acts as a serial-peripheral slave in SPI mode 0 and runs entirely on the serial clock. An active-low select frames each command. Bytes arrive most significant bit first. The first byte of a frame is an op-code. Depending on the op-code, the block then takes a two-byte address, a dummy byte, data bytes or a status byte, or it sends back data. A small parameterized byte array stands in for the storage.

Writes are guarded by a write-enable latch. Only a dedicated op-code sets it, and a direct status write cannot change it. It clears itself once any write has completed. Both the status register and the array can only be changed while the latch is set.

The serial output is brought out as a data bit plus an output enable, and the pad tri-state is built from these two signals. The enable is high only while read data is on the line.

Select is sampled on rising serial-clock edges. The clock must therefore make at least one rising edge while select is high between frames. Raising select aborts whatever command is in progress.

Top module: `spi_mem_slave`

## Requirements
- R1: Every byte is shifted most significant bit first. Input bits are taken on the rising clock edge, and the output bit changes on the falling edge, so a read byte's bit 7 is valid from the falling edge that follows the eighth rising edge of the previous byte.
- R2: Op-code values: 0x06 set latch, 0x04 clear latch, 0x05 read status, 0x01 write status, 0x03 read, 0x0B fast read, 0x02 write, 0xB9 sleep, 0x9F read ID, 0xC3 read serial number. Any other op-code makes the rest of the frame ignored, with the output disabled.
- R3: After reset the latch is 0 and the status byte reads 0x00. The status byte is laid out as bits 7:2 stored control bits, bit 1 the latch, and bit 0 always 0.
- R4: Op-code 0x06 sets the latch and op-code 0x04 clears it. Nothing else can set the latch.
- R5: A status write (0x01 followed by one byte) stores bits 7:2 of that byte. It leaves the latch bit unchanged while the frame is open, whatever value is sent in bit 1.
- R6: A completed write clears the latch when select rises. A write counts as completed after the full status byte, or after at least one full memory data byte. A trailing partial byte is discarded and is not a completed write.
- R7: A status write or memory write that starts while the latch is clear has no effect on the status register, the array or the latch.
- R8: After 0x05 exactly one status byte is returned. The output is disabled for the rest of the frame.
- R9: A read (0x03) takes a 16-bit address, high byte first, and uses only its low log2(DEPTH) bits. Data starts with the next byte. The address increments for each byte and wraps from the last array location to 0.
- R10: A fast read (0x0B) takes one dummy byte after the address, with the output disabled, before data returns as in R9.
- R11: A write (0x02) stores each full data byte at the current address, then increments the address with the same wrap as in R9.
- R12: 0x9F returns the ID bytes and 0xC3 returns the serial-number bytes, first byte first, repeating from the first byte after the last one.
- R13: After a sleep op-code, the whole next frame is ignored with the output disabled. The frame after that behaves normally.
- R14: The output enable is low during reset, while select is high, and during op-code, address, dummy and write bytes. Raising select aborts any command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | Serial clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host (registered on the falling edge) |
| sdo_oe | output | 1 | Output enable for the pad tri-state of sdo |

## Verification
The bench builds the block with a 16-byte array, a 3-byte ID and a 5-byte serial number. With these values, address wrap-around is reached in a short burst, and the upper address bits that the block must ignore are exercised by random addresses. The unequal ID and serial-number lengths make the cyclic repetition of each visible within seven bytes. Random command sequences, mixing latch changes, status writes, write bursts and both read kinds, run against a bench model of the array, latch and status register.

// File: rtl/spi_mem_pkg.sv
`timescale 1ns/1ps
package spi_mem_pkg;

  localparam logic [7:0] OP_SET_WE  = 8'h06;
  localparam logic [7:0] OP_CLR_WE  = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_RD      = 8'h03;
  localparam logic [7:0] OP_RD_FAST = 8'h0B;
  localparam logic [7:0] OP_WR      = 8'h02;
  localparam logic [7:0] OP_SLEEP   = 8'hB9;
  localparam logic [7:0] OP_RD_ID   = 8'h9F;
  localparam logic [7:0] OP_RD_SN   = 8'hC3;

  typedef enum logic [3:0] {
    PH_OPC,
    PH_ADH,
    PH_ADL,
    PH_DUMMY,
    PH_WDATA,
    PH_WSTAT,
    PH_RMEM,
    PH_RSTAT,
    PH_RID,
    PH_RSN,
    PH_IDLE
  } phase_t;

  typedef enum logic [1:0] {
    MD_RD,
    MD_FAST,
    MD_WR
  } mode_t;

endpackage

// File: rtl/spi_mem_rx.sv
`timescale 1ns/1ps
module spi_mem_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       din,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic [2:0] bit_cnt
);

  logic [6:0] sh;

  // the byte completing on this edge includes the bit being sampled now
  assign rx_byte   = {sh, din};
  assign byte_done = !cs_n && (bit_cnt == 3'd7);

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      bit_cnt <= '0;
      sh      <= '0;
    end else begin
      bit_cnt <= bit_cnt + 3'd1;
      sh      <= {sh[5:0], din};
    end
  end

endmodule

// File: rtl/spi_mem_ram.sv
`timescale 1ns/1ps
module spi_mem_ram #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  // single write port and registered read port: block RAM template
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_mem_tx.sv
`timescale 1ns/1ps
module spi_mem_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       load,
  input  logic       drive,
  input  logic       use_mem,
  input  logic [7:0] mem_byte,
  input  logic [7:0] reg_byte,
  output logic       dout,
  output logic       dout_oe
);

  logic [7:0] sh;

  assign dout = sh[7];

  // output side updates on the falling edge so the host samples a settled bit
  always_ff @(negedge clk) begin
    if (rst || cs_n) begin
      sh      <= '0;
      dout_oe <= 1'b0;
    end else if (load) begin
      sh      <= use_mem ? mem_byte : reg_byte;
      dout_oe <= drive;
    end else begin
      sh      <= {sh[6:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_mem_ctrl.sv
`timescale 1ns/1ps
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int ID_BYTES = 4,
  parameter logic [ID_BYTES*8-1:0] ID_VALUE = 32'hC2_25_08_01,
  parameter int SN_BYTES = 4,
  parameter logic [SN_BYTES*8-1:0] SN_VALUE = 32'h5A_A5_3C_C3,
  localparam int AW   = $clog2(DEPTH),
  localparam int MAXB = (ID_BYTES > SN_BYTES) ? ID_BYTES : SN_BYTES,
  localparam int IW   = $clog2(MAXB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          byte_done,
  input  logic [7:0]    rx_byte,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] mem_raddr,
  output logic          drive,
  output logic          use_mem,
  output logic [7:0]    reg_byte
);

  phase_t        phase;
  mode_t         mode;
  logic          wel;
  logic [5:0]    stat_hi;
  logic [7:0]    addr_hi;
  logic [AW-1:0] addr;
  logic [AW-1:0] adl_addr;
  logic [IW-1:0] idx;
  logic          wr_done;
  logic          sleep_req;
  logic          asleep;
  logic          frame_seen;
  logic [7:0]    tx_reg;
  logic [7:0]    stat_byte;
  logic [7:0]    id_sel;
  logic [7:0]    sn_sel;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i, input int n);
    if (int'(i) >= n - 1) return '0;
    return i + 1'b1;
  endfunction

  assign stat_byte = {stat_hi, wel, 1'b0};
  assign adl_addr  = AW'({addr_hi, rx_byte});

  always_comb begin
    id_sel = ID_VALUE[ID_BYTES*8-1 -: 8];
    for (int k = 0; k < ID_BYTES; k++)
      if (int'(idx) == k) id_sel = ID_VALUE[(ID_BYTES-1-k)*8 +: 8];
  end

  always_comb begin
    sn_sel = SN_VALUE[SN_BYTES*8-1 -: 8];
    for (int k = 0; k < SN_BYTES; k++)
      if (int'(idx) == k) sn_sel = SN_VALUE[(SN_BYTES-1-k)*8 +: 8];
  end

  // read address looks one byte ahead so the registered RAM output is ready
  // by the falling edge that starts the next byte
  always_comb begin
    case (phase)
      PH_ADL:  mem_raddr = adl_addr;
      PH_RMEM: mem_raddr = addr + 1'b1;
      default: mem_raddr = addr;
    endcase
  end

  assign mem_we    = byte_done && (phase == PH_WDATA);
  assign mem_waddr = addr;
  assign mem_wdata = rx_byte;
  assign drive     = (phase == PH_RMEM) || (phase == PH_RSTAT) ||
                     (phase == PH_RID)  || (phase == PH_RSN);
  assign use_mem   = (phase == PH_RMEM);
  assign reg_byte  = tx_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_OPC;
      mode       <= MD_RD;
      wel        <= 1'b0;
      stat_hi    <= '0;
      addr_hi    <= '0;
      addr       <= '0;
      idx        <= '0;
      wr_done    <= 1'b0;
      sleep_req  <= 1'b0;
      asleep     <= 1'b0;
      frame_seen <= 1'b0;
      tx_reg     <= '0;
    end else if (cs_n) begin
      phase      <= PH_OPC;
      frame_seen <= 1'b0;
      if (wr_done) begin
        wel     <= 1'b0;
        wr_done <= 1'b0;
      end
      if (sleep_req) begin
        asleep    <= 1'b1;
        sleep_req <= 1'b0;
      end else if (asleep && frame_seen) begin
        asleep <= 1'b0;
      end
    end else begin
      frame_seen <= 1'b1;
      if (byte_done) begin
        case (phase)
          PH_OPC: begin
            phase <= PH_IDLE;
            if (!asleep) begin
              case (rx_byte)
                OP_SET_WE:  wel <= 1'b1;
                OP_CLR_WE:  wel <= 1'b0;
                OP_RD_STAT: begin
                  tx_reg <= stat_byte;
                  phase  <= PH_RSTAT;
                end
                OP_WR_STAT: if (wel) phase <= PH_WSTAT;
                OP_RD: begin
                  mode  <= MD_RD;
                  phase <= PH_ADH;
                end
                OP_RD_FAST: begin
                  mode  <= MD_FAST;
                  phase <= PH_ADH;
                end
                OP_WR: if (wel) begin
                  mode  <= MD_WR;
                  phase <= PH_ADH;
                end
                OP_SLEEP: sleep_req <= 1'b1;
                OP_RD_ID: begin
                  tx_reg <= ID_VALUE[ID_BYTES*8-1 -: 8];
                  idx    <= step('0, ID_BYTES);
                  phase  <= PH_RID;
                end
                OP_RD_SN: begin
                  tx_reg <= SN_VALUE[SN_BYTES*8-1 -: 8];
                  idx    <= step('0, SN_BYTES);
                  phase  <= PH_RSN;
                end
                default: ;
              endcase
            end
          end
          PH_ADH: begin
            addr_hi <= rx_byte;
            phase   <= PH_ADL;
          end
          PH_ADL: begin
            addr <= adl_addr;
            case (mode)
              MD_WR:   phase <= PH_WDATA;
              MD_FAST: phase <= PH_DUMMY;
              default: phase <= PH_RMEM;
            endcase
          end
          PH_DUMMY: phase <= PH_RMEM;
          PH_RMEM:  addr  <= addr + 1'b1;
          PH_WDATA: begin
            addr    <= addr + 1'b1;
            wr_done <= 1'b1;
          end
          PH_WSTAT: begin
            stat_hi <= rx_byte[7:2];
            wr_done <= 1'b1;
            phase   <= PH_IDLE;
          end
          PH_RSTAT: phase <= PH_IDLE;
          PH_RID: begin
            tx_reg <= id_sel;
            idx    <= step(idx, ID_BYTES);
          end
          PH_RSN: begin
            tx_reg <= sn_sel;
            idx    <= step(idx, SN_BYTES);
          end
          default: ;
        endcase
      end
    end
  end

  AST_WEL_SET_ONLY_BY_OPCODE: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(byte_done && phase == PH_OPC && rx_byte == OP_SET_WE && !asleep)); // R4

  AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wel); // R7

  AST_STAT_WRITE_KEEPS_WEL: assert property (@(posedge clk) disable iff (rst)
    (byte_done && phase == PH_WSTAT) |=> (wel || cs_n)); // R5

  AST_WEL_CLEARS_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cs_n && wr_done) |=> !wel); // R6

  AST_NO_WRITE_WHILE_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !asleep); // R13

endmodule

// File: rtl/spi_mem_slave.sv
`timescale 1ns/1ps
module spi_mem_slave #(
  parameter int DEPTH    = 1024,
  parameter int ID_BYTES = 4,
  parameter logic [ID_BYTES*8-1:0] ID_VALUE = 32'hC2_25_08_01,
  parameter int SN_BYTES = 4,
  parameter logic [SN_BYTES*8-1:0] SN_VALUE = 32'h5A_A5_3C_C3,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic sck,
  input  logic rst,
  input  logic sel_n,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);

  logic [7:0]    rx_byte;
  logic          byte_done;
  logic [2:0]    bit_cnt;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic [AW-1:0] mem_raddr;
  logic [7:0]    mem_rdata;
  logic          drive;
  logic          use_mem;
  logic [7:0]    reg_byte;

  spi_mem_rx u_rx (
    .clk       (sck),
    .rst       (rst),
    .cs_n      (sel_n),
    .din       (sdi),
    .rx_byte   (rx_byte),
    .byte_done (byte_done),
    .bit_cnt   (bit_cnt)
  );

  spi_mem_ctrl #(
    .DEPTH    (DEPTH),
    .ID_BYTES (ID_BYTES),
    .ID_VALUE (ID_VALUE),
    .SN_BYTES (SN_BYTES),
    .SN_VALUE (SN_VALUE)
  ) u_ctrl (
    .clk       (sck),
    .rst       (rst),
    .cs_n      (sel_n),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .drive     (drive),
    .use_mem   (use_mem),
    .reg_byte  (reg_byte)
  );

  spi_mem_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (sck),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  spi_mem_tx u_tx (
    .clk      (sck),
    .rst      (rst),
    .cs_n     (sel_n),
    .load     (bit_cnt == 3'd0),
    .drive    (drive),
    .use_mem  (use_mem),
    .mem_byte (mem_rdata),
    .reg_byte (reg_byte),
    .dout     (sdo),
    .dout_oe  (sdo_oe)
  );

  AST_OE_LOW_DESELECTED: assert property (@(posedge sck) disable iff (rst)
    ($past(sel_n) && sel_n) |-> !sdo_oe); // R14

endmodule

// File: tb/tb_spi_mem_slave.sv
`timescale 1ns/1ps
module tb_spi_mem_slave;

  localparam int DEPTH = 16;
  localparam int IDN   = 3;
  localparam logic [IDN*8-1:0] IDV = 24'hA1_B2_C3;
  localparam int SNN   = 5;
  localparam logic [SNN*8-1:0] SNV = 40'h01_23_45_67_89;

  logic sck = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo;
  logic sdo_oe;

  spi_mem_slave #(
    .DEPTH(DEPTH), .ID_BYTES(IDN), .ID_VALUE(IDV), .SN_BYTES(SNN), .SN_VALUE(SNV)
  ) dut (
    .sck(sck), .rst(rst), .sel_n(sel_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always #5 sck = ~sck;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0] mdl [DEPTH];
  logic       m_wel = 1'b0;
  logic [7:0] m_stat = 8'h00;
  logic       m_asleep = 1'b0;

  logic [7:0] got;
  logic       oe_all;
  logic       oe_any;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_exp();
    return {m_stat[7:2], m_wel, 1'b0};
  endfunction

  // inputs change 1 ns after a falling edge; outputs sampled 4 ns after it
  task automatic xb(input logic [7:0] d);
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sdi = d[i];
      #3;
      got[i] = sdo;
      oe_all = oe_all & sdo_oe;
      oe_any = oe_any | sdo_oe;
      @(negedge sck); #1;
    end
  endtask

  task automatic sel();
    @(negedge sck); #1;
    sel_n = 1'b0;
  endtask

  task automatic desel();
    sel_n = 1'b1;
    @(negedge sck); #1;
    @(negedge sck); #1;
    chk(!sdo_oe, "R14 deselected", sdo_oe, 0);
  endtask

  task automatic cmd1(input logic [7:0] op);
    bit ign = m_asleep;
    sel();
    xb(op);
    chk(!oe_any, "R14 single-byte command", oe_any, 0);
    desel();
    if (ign) m_asleep = 1'b0;
    else if (op == 8'h06) m_wel = 1'b1;
    else if (op == 8'h04) m_wel = 1'b0;
    else if (op == 8'hB9) m_asleep = 1'b1;
  endtask

  task automatic rd_status(input string tag);
    bit ign = m_asleep;
    logic [7:0] e = stat_exp();
    sel();
    xb(8'h05);
    xb(8'h00);
    if (ign) chk(!oe_any, {"R13 ignored frame ", tag}, oe_any, 0);
    else chk(oe_all && got == e, {"R1 R3 R8 status ", tag}, {oe_all, got}, {1'b1, e});
    xb(8'h00);
    chk(!oe_any, "R8 one status byte only", oe_any, 0);
    desel();
    if (ign) m_asleep = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] d);
    sel();
    xb(8'h01);
    xb(d);
    chk(!oe_any, "R14 status write byte", oe_any, 0);
    desel();
    if (m_wel) begin
      m_stat = d & 8'hFC;
      m_wel  = 1'b0;
    end
  endtask

  task automatic write_mem(input logic [15:0] a, input int n);
    bit anyoe = 0;
    sel();
    xb(8'h02); anyoe |= oe_any;
    xb(a[15:8]); anyoe |= oe_any;
    xb(a[7:0]);  anyoe |= oe_any;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = 8'($urandom);
      xb(d); anyoe |= oe_any;
      if (m_wel) mdl[(int'(a) + k) % DEPTH] = d;
    end
    desel();
    chk(!anyoe, "R14 write frame", anyoe, 0);
    if (m_wel && n > 0) m_wel = 1'b0;
  endtask

  task automatic read_mem(input logic [15:0] a, input int n, input bit fast, input string tag);
    sel();
    xb(fast ? 8'h0B : 8'h03);
    xb(a[15:8]);
    xb(a[7:0]);
    chk(!oe_any, "R14 address bytes", oe_any, 0);
    if (fast) begin
      xb(8'($urandom));
      chk(!oe_any, "R10 dummy byte", oe_any, 0);
    end
    for (int k = 0; k < n; k++) begin
      logic [7:0] e = mdl[(int'(a) + k) % DEPTH];
      xb(8'($urandom));
      chk(oe_all && got == e, {fast ? "R10 " : "R9 ", tag}, {oe_all, got}, {1'b1, e});
    end
    desel();
  endtask

  task automatic rd_seq(input logic [7:0] op, input int n);
    sel();
    xb(op);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e = (op == 8'h9F) ? IDV[(IDN-1-(k%IDN))*8 +: 8] : SNV[(SNN-1-(k%SNN))*8 +: 8];
      xb(8'h00);
      chk(oe_all && got == e, "R12 id/serial byte", {oe_all, got}, {1'b1, e});
    end
    desel();
  endtask

  initial begin
    repeat (190000) @(posedge sck);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (5) @(negedge sck);
    #1;
    chk(!sdo_oe, "R14 output disabled in reset", sdo_oe, 0);
    rst = 1'b0;
    repeat (2) @(negedge sck);
    #1;

    rd_status("after reset");                    // R3
    cmd1(8'h06); rd_status("latch set");         // R4
    cmd1(8'h04); rd_status("latch cleared");     // R4
    wr_stat(8'hFF); rd_status("gated stat");     // R7
    cmd1(8'h06); wr_stat(8'hFF); rd_status("stat written"); // R5 R6
    cmd1(8'h06); wr_stat(8'h58); rd_status("bit1 sent 0");  // R5 R6

    cmd1(8'h06); write_mem(16'h0000, DEPTH);     // R11 fill
    read_mem(16'h0000, DEPTH, 0, "fill readback");
    write_mem(16'h0005, 3);                      // R7 latch clear: no effect
    read_mem(16'h0000, DEPTH, 0, "R7 gated write");

    // R6: partial byte only, latch must stay set and location unchanged
    cmd1(8'h06);
    sel(); xb(8'h02); xb(8'h00); xb(8'h03);
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; @(negedge sck); #1;
    end
    desel();
    rd_status("R6 partial byte");
    read_mem(16'h0003, 1, 0, "R6 partial discarded");
    cmd1(8'h04);

    cmd1(8'h06); write_mem(16'h7A0E, 5);         // R11 wrap
    read_mem(16'hC30D, 6, 1, "R11 wrap fast");
    read_mem(16'h000F, 3, 0, "wrap");

    rd_seq(8'h9F, 7);
    rd_seq(8'hC3, 7);

    // R2: unknown op-code, later bytes in the frame ignored
    sel(); xb(8'h55); xb(8'h06); xb(8'h05); xb(8'h00);
    chk(!oe_any, "R2 unknown op-code frame", oe_any, 0);
    desel();
    rd_status("R2 after unknown");

    // R14: abort mid-command
    sel(); xb(8'h03); xb(8'h00); desel();
    rd_status("R14 after abort");

    // R13: sleep consumes the next frame
    cmd1(8'hB9); cmd1(8'h06); rd_status("R13 wake frame ignored");
    cmd1(8'hB9); rd_status("R13 asleep"); rd_status("R13 awake");

    for (int it = 0; it < 250; it++) begin
      int kind = int'($urandom % 7);
      logic [15:0] a = 16'($urandom);
      int n = 1 + int'($urandom % 5);
      case (kind)
        0: cmd1(8'h06);
        1: cmd1(8'h04);
        2: write_mem(a, n);
        3: read_mem(a, n, 0, "random");
        4: read_mem(a, n, 1, "random");
        5: rd_status("random");
        default: wr_stat(8'($urandom));
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule